// File: doc/BRIEF.md
# Scan Clock Gating Controller

This block paces the test clock of a serial test bus master. The master has three outgoing serial channels (test data out and two mode-select lines) and one incoming channel (test data in). Each channel has a mode enable bit and a ready flag. An outgoing channel is ready when it holds a bit to send. The incoming channel is ready when it has room for a bit. A cycle counter that limits the number of test clocks has its own enable and reports a done flag.

The controller starts a test clock pulse only when every enabled channel is ready, and only while an enabled counter has not reached its end. Disabled channels play no part in this check. While a test clock pulse is high, the block sends a one-cycle shift strobe to each enabled channel and a tick to the counter, so that storage and counter advance in step with the scan bus. The test clock runs at half the system clock rate at most. A status bit shows whether the clock is currently running. Channel storage and the counter itself are outside this block.

Top module: `scan_gate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `tck`, every `shift_stb` bit, `cnt_tick` and `tck_running` are 0.
- R2: While every enabled channel stays ready, `tck` alternates high and low on successive system clocks, one test clock per two system clocks. In each cycle that `tck` is high, `shift_stb` equals the `chan_en` value that was applied when that pulse was decided. In every low cycle, `shift_stb` is 0.
- R3: If any enabled channel is not ready while `tck` is low, `tck` stays low in the next cycle and no strobe is issued.
- R4: A disabled channel's ready flag has no effect on pacing, and a disabled channel never receives a strobe. The channel bit order is 0 test data out, 1 mode select 0, 2 mode select 1, 3 test data in.
- R5: With `cnt_en` high, a high `cnt_done` seen while `tck` is low keeps `tck` low. With `cnt_en` low, `cnt_done` is ignored.
- R6: If no channel is enabled and `cnt_en` is low, `tck` stays low.
- R7: `tck` is never high for two consecutive system clocks. A pulse can only start from the low phase, so each pulse is complete.
- R8: `tck_running` is 1 whenever `tck` is high. It clears at the first low-phase decision that does not start a pulse.
- R9: `cnt_tick` is high exactly in the cycles where `tck` is high and the pulse was started with `cnt_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 4 | Per-channel mode enable (bit order as in R4) |
| chan_rdy | input | 4 | Per-channel ready (out: bit available, in: space available) |
| cnt_en | input | 1 | Cycle counter takes part in pacing |
| cnt_done | input | 1 | Cycle counter has reached its end |
| tck | output | 1 | Generated test clock |
| shift_stb | output | 4 | One-cycle shift strobe per channel, high with `tck` |
| cnt_tick | output | 1 | Decrement request to the cycle counter |
| tck_running | output | 1 | Status: test clock running |

## Verification
The pacing rule is tried with all channels enabled and ready, with a partial enable set whose disabled channels are not ready, and with an enabled channel whose ready flag drops in the middle of a run and then returns. These patterns separate a design that honours the enables from one that ignores them or checks every channel. The counter is run enabled, enabled and then done, and disabled with done held high, and also as the only participant, to show that done is masked correctly. An all-idle pattern shows that the clock stays stopped. On every sampled cycle the bench checks the strobes against the enables and checks that the clock is never high for two cycles in a row.

// File: rtl/scan_gate_pkg.sv
// Package: shared constants for the scan clock gating controller.
// Assumes channel bit positions are fixed; neighbouring storage decodes them.
package scan_gate_pkg;
    localparam int NUM_OUT = 3;
    localparam int NUM_IN  = 1;
    localparam int NUM_CH  = NUM_OUT + NUM_IN;
    localparam int CH_DOUT = 0;
    localparam int CH_SEL0 = 1;
    localparam int CH_SEL1 = 2;
    localparam int CH_DIN  = 3;
endpackage

// File: rtl/scan_gate_ready.sv
// Module: combines enables, ready flags and counter state into one go flag.
// Assumes all inputs are synchronous to the system clock. Purely combinational.
module scan_gate_ready #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] chan_en,
    input  logic [NCH-1:0] chan_rdy,
    input  logic           cnt_en,
    input  logic           cnt_done,
    output logic           go
);
    logic [NCH-1:0] ch_ok;
    logic           any_part;
    logic           cnt_ok;

    // Per channel: a disabled channel never blocks, an enabled one must be ready.
    for (genvar i = 0; i < NCH; i++) begin : g_ok
        assign ch_ok[i] = ~chan_en[i] | chan_rdy[i];
    end

    // Go when someone participates, all are ready and the counter is not finished.
    always_comb begin
        any_part = (|chan_en) | cnt_en;
        cnt_ok   = ~(cnt_en & cnt_done);
        go       = any_part & (&ch_ok) & cnt_ok;
    end
endmodule

// File: rtl/scan_gate_phase.sv
// Module: test clock phase register and running status.
// Assumes a pulse may start only from the low phase; a high phase always ends after one cycle.
module scan_gate_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic fire,
    output logic tck,
    output logic running
);
    logic tck_q;
    logic run_q;

    // A pulse starts when the clock is low and pacing allows it.
    assign fire = ~tck_q & go;

    // Phase toggle: rise on fire, always fall after a high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tck_q <= 1'b0;
        else        tck_q <= fire;
    end

    // Status updates only at low-phase decisions.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (!tck_q) run_q <= go;
    end

    assign tck     = tck_q;
    assign running = run_q;
endmodule

// File: rtl/scan_gate_strobe.sv
// Module: per-channel shift strobes and counter tick, aligned with the high phase.
// Assumes enables are sampled at the same edge that starts the pulse.
module scan_gate_strobe #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic [NCH-1:0] chan_en,
    input  logic           cnt_en,
    output logic [NCH-1:0] shift_stb,
    output logic           cnt_tick
);
    // One strobe register per channel, generated.
    for (genvar i = 0; i < NCH; i++) begin : g_stb
        logic stb_q;
        // Strobe the channel when a pulse starts and the channel is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= fire & chan_en[i];
        end
        assign shift_stb[i] = stb_q;
    end

    logic tick_q;
    // Counter tick with each pulse started while the counter participates.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= fire & cnt_en;
    end
    assign cnt_tick = tick_q;
endmodule

// File: rtl/scan_gate_ctrl.sv
// Module: top of the scan clock gating controller.
// Stops and restarts the test clock from channel readiness and counter state.
// Assumes all inputs are synchronous to clk; tck runs at half the clk rate at most.
module scan_gate_ctrl
    import scan_gate_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan_en,
    input  logic [NCH-1:0] chan_rdy,
    input  logic           cnt_en,
    input  logic           cnt_done,
    output logic           tck,
    output logic [NCH-1:0] shift_stb,
    output logic           cnt_tick,
    output logic           tck_running
);
    logic go;
    logic fire;

    scan_gate_ready #(.NCH(NCH)) u_ready (
        .chan_en (chan_en),
        .chan_rdy(chan_rdy),
        .cnt_en  (cnt_en),
        .cnt_done(cnt_done),
        .go      (go)
    );

    scan_gate_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .fire   (fire),
        .tck    (tck),
        .running(tck_running)
    );

    scan_gate_strobe #(.NCH(NCH)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .chan_en  (chan_en),
        .cnt_en   (cnt_en),
        .shift_stb(shift_stb),
        .cnt_tick (cnt_tick)
    );
endmodule

// File: rtl/scan_gate_ctrl_chk.sv
// Module: property checker bound to scan_gate_ctrl; observes ports only.
module scan_gate_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] chan_rdy,
    input logic           cnt_en,
    input logic           cnt_done,
    input logic           tck,
    input logic [NCH-1:0] shift_stb,
    input logic           cnt_tick,
    input logic           tck_running
);
    // R7: a high phase lasts one cycle
    a_r7_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        tck |=> !tck);
    // R2: strobes only appear with the high phase
    a_r2_stb_with_tck: assert property (@(posedge clk) disable iff (!rst_n)
        (|shift_stb) |-> tck);
    // R4: no strobe to a channel that was disabled at the decision
    a_r4_stb_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb & ~$past(chan_en)) == '0);
    // R3: an enabled channel that is not ready holds the clock low
    a_r3_hold_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck && ((chan_en & ~chan_rdy) != '0)) |=> !tck);
    // R5: finished counter holds the clock low
    a_r5_cnt_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck && cnt_en && cnt_done) |=> !tck);
    // R6: nothing enabled keeps the clock stopped
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck && chan_en == '0 && !cnt_en) |=> !tck);
    // R8: status is set while the clock is high
    a_r8_status: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> tck_running);
    // R9: counter tick only with the high phase
    a_r9_tick_with_tck: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> tck);
endmodule

bind scan_gate_ctrl scan_gate_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .chan_rdy   (chan_rdy),
    .cnt_en     (cnt_en),
    .cnt_done   (cnt_done),
    .tck        (tck),
    .shift_stb  (shift_stb),
    .cnt_tick   (cnt_tick),
    .tck_running(tck_running)
);

// File: tb/scan_gate_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module scan_gate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan_en = '0;
    logic [3:0] chan_rdy = '0;
    logic       cnt_en = 1'b0;
    logic       cnt_done = 1'b0;
    logic       tck;
    logic [3:0] shift_stb;
    logic       cnt_tick;
    logic       tck_running;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    scan_gate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_rdy(chan_rdy),
        .cnt_en(cnt_en), .cnt_done(cnt_done), .tck(tck), .shift_stb(shift_stb),
        .cnt_tick(cnt_tick), .tck_running(tck_running)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Observe n cycles; count pulses and check strobes and ticks per cycle.
    task automatic watch(input int n, input logic [3:0] exp_stb, input bit exp_tick,
                         input int exp_pulses, input bit exp_run, input string req);
        int  pulses = 0;
        int  bad = 0;
        bit  prev = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tck) begin
                pulses++;
                if (shift_stb !== exp_stb || cnt_tick !== exp_tick || !tck_running) bad++;
                if (prev) bad++; // R7: never high twice in a row
            end else if (shift_stb !== 4'h0 || cnt_tick !== 1'b0) bad++;
            prev = tck;
        end
        chk(pulses == exp_pulses, req, "pulse count", pulses, exp_pulses);
        chk(bad == 0, req, "per-cycle strobe/tick/R7/R8 errors", bad, 0);
        chk(tck_running == exp_run, req, "R8 running status", tck_running, exp_run);
    endtask

    task automatic halt();
        chan_en = '0; cnt_en = 1'b0; cnt_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tck == 0 && shift_stb == 0 && cnt_tick == 0 && tck_running == 0,
            "R1", "reset outputs", {tck, shift_stb, cnt_tick, tck_running}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_full_run();
        chan_en = 4'hF; chan_rdy = 4'hF;
        watch(20, 4'hF, 1'b0, 10, 1'b1, "R2");
        halt();
    endtask

    task automatic t_partial();
        // R4: channels 1 and 2 disabled and not ready; run must still proceed
        chan_en = 4'b1001; chan_rdy = 4'b1001;
        watch(16, 4'b1001, 1'b0, 8, 1'b1, "R4");
        halt();
    endtask

    task automatic t_not_ready();
        chan_en = 4'hF; chan_rdy = 4'b1011; // R3: channel 2 enabled, not ready
        watch(10, 4'hF, 1'b0, 0, 1'b0, "R3");
        halt();
    endtask

    task automatic t_stall_mid();
        chan_en = 4'b0011; chan_rdy = 4'b0011;
        do @(negedge clk); while (!tck);
        chan_rdy = 4'b0001; // R3: drop ready during the high phase
        watch(8, 4'b0011, 1'b0, 0, 1'b0, "R3");
        chan_rdy = 4'b0011;
        watch(10, 4'b0011, 1'b0, 5, 1'b1, "R3");
        halt();
    endtask

    task automatic t_counter();
        chan_en = 4'b0001; chan_rdy = 4'hF; cnt_en = 1'b1; cnt_done = 1'b0;
        watch(10, 4'b0001, 1'b1, 5, 1'b1, "R9");
        do @(negedge clk); while (!tck);
        cnt_done = 1'b1; // R5: done stops the clock
        watch(8, 4'b0001, 1'b1, 0, 1'b0, "R5");
        cnt_en = 1'b0; // R5: done ignored when counter disabled
        watch(12, 4'b0001, 1'b0, 6, 1'b1, "R5");
        halt();
        cnt_en = 1'b1; cnt_done = 1'b0; chan_en = '0; // R9: counter alone
        watch(8, 4'b0000, 1'b1, 4, 1'b1, "R9");
        halt();
    endtask

    task automatic t_idle();
        chan_en = '0; cnt_en = 1'b0; chan_rdy = 4'hF; cnt_done = 1'b0;
        watch(10, 4'h0, 1'b0, 0, 1'b0, "R6");
    endtask

    initial begin
        t_reset();
        t_full_run();
        t_partial();
        t_not_ready();
        t_stall_mid();
        t_counter();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2ms;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule